// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block sits on the controller side of an SDRAM and runs read accesses for a small set of chip-select spaces. Each space has its own CAS latency setting. A host hands over a request that carries the space, a row/column address and a size (a single word or a four-beat burst). The sequencer then opens the row with an activate command. It issues one column READ per beat, with the auto-precharge line raised, and takes each returning word off the data bus once the latency of that space has elapsed. After the last beat it inserts one idle transfer cycle and then a precharge wait cycle. In that wait cycle it signals completion.

The request side uses a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While a sequence runs, `req_ready` stays low and the request pins have no effect. The read-data side cannot apply back-pressure, because the SDRAM cannot be stalled once a READ has been issued. `rd_valid` marks a word that the host must take in that same cycle. Refresh, writes and mode-register setup belong to other logic.

Top module: `sdram_burst_rd`

## Requirements
- R1: `req_ready` is high exactly when the sequencer is idle. A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and the activate cycle (t=0) is the next clock cycle. Request pins asserted while a sequence runs are ignored and do not start a second sequence.
- R2: The effective CAS latency L is taken from the 3-bit field `cfg_lat[3*s+2:3*s]` of the selected space s. A value of 0 gives L=1, values 1 to 4 are used as given, and values 5 to 7 give L=4.
- R3: In the activate cycle (t=0) `sd_ras_n` is 0, `sd_cas_n` is 1, `sd_we_n` is 1, and `sd_addr` carries the row, which is `req_addr[21:9]`.
- R4: In each column cycle t=1..N, `sd_cas_n` is 0 and `sd_ras_n` and `sd_we_n` are 1. `sd_addr[8:0]` carries the column `req_addr[8:0]`, and `sd_addr[10]` (the auto-precharge line) is 1. All other address bits are 0.
- R5: `rd_valid` is 1 exactly in cycles t = 1+L .. N+L, and in those cycles `rd_data` equals `sd_dq`. In every other cycle `rd_valid` is 0 and `rd_data` is 0.
- R6: Exactly one idle cycle (t=N+L+1) with no command and no data follows the last beat. `done` is 1 only in the following cycle (t=N+L+2), and the cycle after that is idle.
- R7: `sd_cs_n[s]` is 0 for t=0..N and 1 otherwise. Every other chip select stays 1 throughout.
- R8: Every bit of `sd_dqm` is 0 for t=0..N+L and 1 otherwise.
- R9: `req_burst`=1 gives N=4 beats, and column cycle k (k=1..4) drives column bits [1:0] as k-1. `req_burst`=0 gives N=1 beat with the column unchanged.
- R10: After reset the sequencer is idle: `req_ready` is 1, all commands and chip selects are 1, `sd_dqm` is all ones, and `rd_valid` and `done` are 0.
- R11: The latency, space, size and address are fixed at acceptance. A change of `cfg_lat` or of the request pins during a sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_burst | input | 1 | 1 = four-beat burst, 0 = single read |
| req_space | input | 1 | Chip-select space of the access |
| req_addr | input | 22 | Row in [21:9], column in [8:0] |
| cfg_lat | input | 6 | 3-bit CAS latency setting per space |
| rd_valid | output | 1 | Read word present this cycle, no back-pressure |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle pulse in the precharge wait cycle |
| sd_cs_n | output | 2 | Chip selects, one per space, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, held high |
| sd_dqm | output | 2 | Byte-lane masks, active high |
| sd_addr | output | 13 | SDRAM address bus |
| sd_dq | input | 16 | SDRAM read data |

## Verification
Every result is tied to a cycle index t that counts from the activate cycle. That cycle is the clock after the accepting edge. Commands fall at t=0 and t=1..N, data at t=1+L..N+L, the idle gap at N+L+1 and `done` at N+L+2, with `req_ready` returning at N+L+3. The bench sweeps both spaces, both sizes and all eight latency codes, with the other space holding a different code. At each t it samples every output after the falling edge against values derived from N and L alone. A fresh data word is placed on `sd_dq` in every cycle, so a beat taken one cycle early or late shows up as a wrong word.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // Sequencer phases, one per cycle type of an access
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT,     // row activate
    PH_ACCESS,  // column commands and data beats
    PH_GAP,     // single idle transfer cycle
    PH_PRE      // precharge wait, completion
  } phase_e;

  localparam int BURST_BEATS = 4;
  localparam int BEAT_W      = $clog2(BURST_BEATS);
  localparam int LAT_W       = 3;
  localparam int LAT_MAX     = 4;

  // Map a raw latency code onto the supported range 1..4
  function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
    if (raw == '0)
      return LAT_W'(1);
    else if (raw > LAT_W'(LAT_MAX))
      return LAT_W'(LAT_MAX);
    else
      return raw;
  endfunction

endpackage

// File: rtl/sdram_lat_sel.sv
module sdram_lat_sel
  import sdram_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  localparam int SPACE_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [NUM_CS*LAT_W-1:0] cfg_lat,
  input  logic [SPACE_W-1:0]      space,
  output logic [LAT_W-1:0]        lat
);

  logic [LAT_W-1:0] lat_c [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_space
    assign lat_c[i] = clamp_lat(cfg_lat[i*LAT_W +: LAT_W]);
  end

  assign lat = lat_c[space];

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  localparam int SPACE_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_burst,
  input  logic [SPACE_W-1:0] req_space,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [LAT_W-1:0]   lat_in,
  output logic               req_ready,
  output phase_e             phase,
  output logic [3:0]         tcnt,
  output logic [LAT_W-1:0]   lat_q,
  output logic [2:0]         nbeat_q,
  output logic               burst_q,
  output logic [SPACE_W-1:0] space_q,
  output logic [ROW_W-1:0]   row_q,
  output logic [COL_W-1:0]   col_q
);

  logic [3:0] last_dat;
  assign last_dat  = {1'b0, nbeat_q} + {1'b0, lat_q};
  assign req_ready = (phase == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tcnt    <= '0;
      lat_q   <= LAT_W'(1);
      nbeat_q <= 3'd1;
      burst_q <= 1'b0;
      space_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase   <= PH_ACT;
            tcnt    <= '0;
            lat_q   <= lat_in;
            burst_q <= req_burst;
            nbeat_q <= req_burst ? 3'(BURST_BEATS) : 3'd1;
            space_q <= req_space;
            row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q   <= req_addr[COL_W-1:0];
          end
        end
        PH_ACT: begin
          phase <= PH_ACCESS;
          tcnt  <= 4'd1;
        end
        PH_ACCESS: begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == last_dat) phase <= PH_GAP;
        end
        PH_GAP: begin
          tcnt  <= tcnt + 4'd1;
          phase <= PH_PRE;
        end
        PH_PRE: begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_LAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (lat_q >= LAT_W'(1) && lat_q <= LAT_W'(LAT_MAX))); // R2

  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> (phase != PH_ACT)); // R1

  AST_GAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP) |=> (phase == PH_PRE)); // R6

  AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> ($stable(lat_q) && $stable(space_q) && $stable(nbeat_q))); // R11

endmodule

// File: rtl/sdram_rd_pins.sv
module sdram_rd_pins
  import sdram_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DW     = 16,
  localparam int SPACE_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int DQM_W   = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase,
  input  logic [3:0]         tcnt,
  input  logic [LAT_W-1:0]   lat_q,
  input  logic [2:0]         nbeat_q,
  input  logic               burst_q,
  input  logic [SPACE_W-1:0] space_q,
  input  logic [ROW_W-1:0]   row_q,
  input  logic [COL_W-1:0]   col_q,
  input  logic [DW-1:0]      sd_dq,
  output logic [NUM_CS-1:0]  sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [DQM_W-1:0]   sd_dqm,
  output logic [ADDR_W-1:0]  sd_addr,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               done
);

  logic [3:0] lat4, nb4;
  logic       in_act, in_col, in_dat, cs_on, mask_off;
  logic [COL_W-1:0] col_v;

  assign lat4 = {1'b0, lat_q};
  assign nb4  = {1'b0, nbeat_q};

  assign in_act   = (phase == PH_ACT);
  assign in_col   = (phase == PH_ACCESS) && (tcnt <= nb4);
  assign in_dat   = (phase == PH_ACCESS) && (tcnt >= lat4 + 4'd1) && (tcnt <= nb4 + lat4);
  assign cs_on    = in_act || in_col;
  assign mask_off = in_act || (phase == PH_ACCESS);

  // Column of the current beat: low bits step through the burst
  always_comb begin
    col_v = col_q;
    if (burst_q) col_v[BEAT_W-1:0] = BEAT_W'(tcnt[BEAT_W-1:0] - BEAT_W'(1));
  end

  always_comb begin
    sd_addr = '0;
    if (in_act) begin
      sd_addr[ROW_W-1:0] = row_q;
    end else if (in_col) begin
      sd_addr[COL_W-1:0] = col_v;
      sd_addr[AP_BIT]    = 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign sd_cs_n[i] = !(cs_on && (space_q == SPACE_W'(i)));
  end

  assign sd_ras_n = !in_act;
  assign sd_cas_n = !in_col;
  assign sd_we_n  = 1'b1;
  assign sd_dqm   = mask_off ? '0 : '1;
  assign rd_valid = in_dat;
  assign rd_data  = in_dat ? sd_dq : '0;
  assign done     = (phase == PH_PRE);

  AST_RAS_CAS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_ras_n |-> sd_cas_n); // R3

  AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cas_n |-> sd_addr[AP_BIT]); // R4

  AST_DATA_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (sd_dqm == '0)); // R8

  AST_CS_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sd_cs_n) <= 1); // R7

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdram_rd_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DW     = 16,
  localparam int SPACE_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int DQM_W   = DW / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_burst,
  input  logic [SPACE_W-1:0]      req_space,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [NUM_CS*LAT_W-1:0] cfg_lat,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  output logic                    done,
  output logic [NUM_CS-1:0]       sd_cs_n,
  output logic                    sd_ras_n,
  output logic                    sd_cas_n,
  output logic                    sd_we_n,
  output logic [DQM_W-1:0]        sd_dqm,
  output logic [ADDR_W-1:0]       sd_addr,
  input  logic [DW-1:0]           sd_dq
);

  phase_e             phase;
  logic [3:0]         tcnt;
  logic [LAT_W-1:0]   lat_sel, lat_q;
  logic [2:0]         nbeat_q;
  logic               burst_q;
  logic [SPACE_W-1:0] space_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;

  sdram_lat_sel #(.NUM_CS(NUM_CS)) u_lat (
    .cfg_lat (cfg_lat),
    .space   (req_space),
    .lat     (lat_sel)
  );

  sdram_rd_seq #(.NUM_CS(NUM_CS), .ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_burst (req_burst),
    .req_space (req_space),
    .req_addr  (req_addr),
    .lat_in    (lat_sel),
    .req_ready (req_ready),
    .phase     (phase),
    .tcnt      (tcnt),
    .lat_q     (lat_q),
    .nbeat_q   (nbeat_q),
    .burst_q   (burst_q),
    .space_q   (space_q),
    .row_q     (row_q),
    .col_q     (col_q)
  );

  sdram_rd_pins #(.NUM_CS(NUM_CS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
                  .AP_BIT(AP_BIT), .DW(DW)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .tcnt     (tcnt),
    .lat_q    (lat_q),
    .nbeat_q  (nbeat_q),
    .burst_q  (burst_q),
    .space_q  (space_q),
    .row_q    (row_q),
    .col_q    (col_q),
    .sd_dq    (sd_dq),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dqm   (sd_dqm),
    .sd_addr  (sd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .done     (done)
  );

  // Beats delivered in the current sequence, checked at completion
  logic [2:0] beats_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               beats_seen <= '0;
    else if (phase == PH_ACT) beats_seen <= '0;
    else if (rd_valid)        beats_seen <= beats_seen + 3'd1;
  end

  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beats_seen == nbeat_q)); // R9

  AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_GAP)); // R6

  AST_GAP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (!done && sd_cas_n)); // R6

endmodule

// File: tb/sim_sdram_burst_rd.sv
module sim_sdram_burst_rd;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_burst = 1'b0;
  logic [0:0]  req_space = '0;
  logic [21:0] req_addr = '0;
  logic [5:0]  cfg_lat = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        done;
  logic [1:0]  sd_cs_n;
  logic        sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_dqm;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_rd u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_burst(req_burst), .req_space(req_space), .req_addr(req_addr),
    .cfg_lat(cfg_lat), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_addr(sd_addr), .sd_dq(sd_dq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff_lat(input int code);
    if (code == 0) return 1;
    if (code > 4) return 4;
    return code;
  endfunction

  task automatic run_seq(input int sp, input int burst, input int code, input bit disturb, input int run);
    int nb, lat;
    logic [12:0] row;
    logic [8:0]  col, colk, tv;
    logic [12:0] exp_addr;
    logic [1:0]  exp_cs;
    logic [15:0] pat;
    string sfx;
    nb  = burst ? 4 : 1;
    lat = eff_lat(code);
    row = 13'(run * 211 + 5);
    col = 9'(run * 37 + 2);
    sfx = disturb ? " R11" : "";
    @(negedge clk);
    cfg_lat = '0;
    cfg_lat[sp*3 +: 3]     = 3'(code);
    cfg_lat[(1-sp)*3 +: 3] = 3'(7 - code);
    req_space = 1'(sp);
    req_burst = 1'(burst);
    req_addr  = {row, col};
    req_valid = 1'b1;
    #1;
    chk("R1 ready before accept", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    for (int t = 0; t <= nb + lat + 2; t++) begin
      @(negedge clk);
      if (t == 0 && !disturb) req_valid = 1'b0;
      if (disturb && t == 1) begin
        req_addr  = ~req_addr;
        req_burst = ~req_burst;
        req_space = ~req_space;
        cfg_lat   = ~cfg_lat;
      end
      if (disturb && t == 3) req_valid = 1'b0;
      pat = 16'h5A00 ^ {8'(run), 8'(t)};
      sd_dq = pat;
      #1;
      // Expected values from the cycle index alone
      exp_addr = '0;
      colk = col;
      if (burst != 0) begin
        tv = 9'(t - 1);
        colk[1:0] = tv[1:0];
      end
      if (t == 0) exp_addr = row;
      else if (t <= nb) exp_addr = {2'b00, 1'b1, 1'b0, colk};
      exp_cs = 2'b11;
      if (t <= nb) exp_cs[sp] = 1'b0;
      chk({"R1 busy ready", sfx}, {31'd0, req_ready}, 32'd0);
      chk({"R3 R4 command ras/cas/we", sfx}, {29'd0, sd_ras_n, sd_cas_n, sd_we_n},
          {29'd0, (t != 0), !(t >= 1 && t <= nb), 1'b1});
      chk({"R4 R9 address", sfx}, {19'd0, sd_addr}, {19'd0, exp_addr});
      chk({"R7 chip select", sfx}, {30'd0, sd_cs_n}, {30'd0, exp_cs});
      chk({"R8 byte mask", sfx}, {30'd0, sd_dqm}, (t <= nb + lat) ? 32'd0 : 32'd3);
      if (t >= 1 + lat && t <= nb + lat)
        chk({"R5 R2 data beat", sfx}, {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, pat});
      else
        chk({"R5 R2 no data", sfx}, {15'd0, rd_valid, rd_data}, 32'd0);
      chk({"R6 done", sfx}, {31'd0, done}, {31'd0, (t == nb + lat + 2)});
    end
    @(negedge clk);
    #1;
    chk("R6 R1 idle after done", {26'd0, req_ready, sd_ras_n, sd_cas_n, sd_cs_n, done},
        {26'd0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0});
  endtask

  initial begin
    int run;
    run = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset outputs",
        {22'd0, req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, rd_valid, done},
        {22'd0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10 idle after release", {31'd0, req_ready}, 32'd1);
    for (int sp = 0; sp < 2; sp++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 8; c++) begin
          run_seq(sp, b, c, (c == 3) || (c == 6), run);
          run++;
        end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule